// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Selector

This block holds the digital dividers of a PLL frequency synthesizer. It runs on one system clock. The reference, oscillator and serial clocks do not enter as clocks. Each arrives as a one-cycle strobe, and a strobe marks one transition (rising or falling) of that source, so one source period is two strobes. From these strobes the block builds four registered clock levels:
- a reference clock divided by sixteen, which feeds phase comparison;
- a feedback clock at the oscillator frequency divided by 2·M, so that the loop settles at f_vco = 2·M·f_ref/16;
- an output clock at the oscillator frequency divided by N;
- a selectable test signal.

A separate loader supplies the 9-bit M value, the 2-bit N code and the 3-bit test code. The loader also supplies the current bit of its serial shift register. This block does not judge lock or frequency.

All dividers are built from one counter module. Each counter has two phases:
- **counting**: it advances on each strobe of its source, and on the last count it toggles its output and wraps to zero;
- **restart**: it enters this phase for one cycle whenever its divide value differs from the value it used in the previous cycle, and it clears its count there.

An eight-way selector, written as a `unique case` over a named enumeration, chooses what drives the test pin.

Top module: `synth_div_chain`

## Requirements
- R1: While `rst` is high, every divider count clears and `ref_div_o`, `fb_o` and `fout_o` are low in the cycle after each reset edge.
- R2: `ref_div_o` toggles once per 16 `ref_edge` strobes. With a strobe in every cycle, it rises 16 cycles after reset release and then toggles every 16 cycles.
- R3: `fout_o` toggles once per N `vco_edge` strobes, which gives a 50% duty cycle. The N code maps as 00→2, 01→4, 10→8 and 11→1; with code 11, `fout_o` replicates the oscillator.
- R4: `fb_o` toggles once per 2·M `vco_edge` strobes, which makes its period M oscillator periods ×2. M is the unsigned value of `m_val` (bit 8 weighs 256, bit 0 weighs 1).
- R5: An `m_val` of 0 or 1 is treated as M = 2, on both the feedback path and the serial path.
- R6: When a divider's divide value changes, the divider clears its count in the next cycle, and any strobe in that cycle is not counted. The next toggle therefore follows ratio + 1 strobe cycles.
- R7: The test code sets `test_o` as follows: 000 gives `shift_q`, 001 gives constant 1, 101 gives constant 0, and 100 gives `fout_o`.
- R8: Test code 010 drives `test_o` from the ÷16 reference clock, and code 011 drives it from the feedback clock.
- R9: Test code 110 drives `test_o` from the serial strobes divided by 2·M, with the same clamp as in R5.
- R10: Test code 111 drives `test_o` from the output clock divided by 4, which is one toggle per four `fout_o` transitions.
- R11: A divided output changes only in the cycle after a strobe of its own source. Without strobes, every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| ref_edge | input | 1 | One pulse per reference clock transition |
| vco_edge | input | 1 | One pulse per oscillator transition |
| ser_edge | input | 1 | One pulse per serial clock transition |
| m_val | input | 9 | Feedback divide value M |
| n_code | input | 2 | Output divider code |
| test_code | input | 3 | Test pin source select |
| shift_q | input | 1 | Serial shift register output bit from the loader |
| ref_div_o | output | 1 | Reference clock ÷16 |
| fb_o | output | 1 | Feedback clock, oscillator ÷2M |
| fout_o | output | 1 | Output clock, oscillator ÷N |
| test_o | output | 1 | Selected test signal |

## Verification
Two things can fall in the same cycle: a change of divide value and a strobe of that divider's source. The bench provokes this by rewriting N, and separately M, in the half-cycle right after an output toggle while the oscillator strobe stays high in every cycle. It then judges the result by the gap to the next toggle, which must be the new ratio plus one cycle, and by the gap after that, which must be the bare new ratio. A second coincidence is the ÷4 test path counting an output-clock toggle in the same edge that produces it; the bench judges this by expecting exactly 4·N cycles per test-pin toggle.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [2:0] {
        TS_SHIFT = 3'b000,
        TS_HIGH  = 3'b001,
        TS_REF   = 3'b010,
        TS_FB    = 3'b011,
        TS_FOUT  = 3'b100,
        TS_LOW   = 3'b101,
        TS_SER   = 3'b110,
        TS_QUART = 3'b111
    } tsel_e;

    typedef enum logic [1:0] {
        NC_DIV2 = 2'b00,
        NC_DIV4 = 2'b01,
        NC_DIV8 = 2'b10,
        NC_DIV1 = 2'b11
    } ncode_e;

    localparam int N_RATIO_W = 4;

    function automatic logic [N_RATIO_W-1:0] n_ratio(input logic [1:0] code);
        logic [N_RATIO_W-1:0] r;
        unique case (ncode_e'(code))
            NC_DIV2: r = 4'd2;
            NC_DIV4: r = 4'd4;
            NC_DIV8: r = 4'd8;
            NC_DIV1: r = 4'd1;
            default: r = 4'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sd_edge_div.sv
module sd_edge_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] ratio,
    output logic         clk_o,
    output logic         edge_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;
    logic [W-1:0] ratio_q;
    logic [W-1:0] eff_q;
    logic         restart;

    assign eff_q   = (ratio_q == '0) ? ONE : ratio_q;
    assign restart = (ratio != ratio_q);
    assign edge_o  = stb && !restart && (cnt == eff_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            clk_o   <= 1'b0;
            ratio_q <= ratio;
        end else begin
            ratio_q <= ratio;
            if (restart) begin
                cnt <= '0;
            end else if (edge_o) begin
                cnt   <= '0;
                clk_o <= ~clk_o;
            end else if (stb) begin
                cnt <= cnt + ONE;
            end
        end
    end

    assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stb)) |-> $stable(clk_o));

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < eff_q);

    assert_restart_on_change_R6: assert property (@(posedge clk) disable iff (rst)
        (ratio != ratio_q) |=> (cnt == '0));

endmodule

// File: rtl/sd_test_sel.sv
module sd_test_sel
    import synth_div_pkg::*;
(
    input  logic [2:0] code,
    input  logic       shift_q,
    input  logic       ref_div,
    input  logic       fb,
    input  logic       fout,
    input  logic       ser_div,
    input  logic       quart,
    output logic       test_o
);
    always_comb begin
        unique case (tsel_e'(code))
            TS_SHIFT: test_o = shift_q;
            TS_HIGH:  test_o = 1'b1;
            TS_REF:   test_o = ref_div;
            TS_FB:    test_o = fb;
            TS_FOUT:  test_o = fout;
            TS_LOW:   test_o = 1'b0;
            TS_SER:   test_o = ser_div;
            TS_QUART: test_o = quart;
            default:  test_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import synth_div_pkg::*;
#(
    parameter int MW      = 9,
    parameter int REF_DIV = 16,
    parameter int QDIV    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_edge,
    input  logic          vco_edge,
    input  logic          ser_edge,
    input  logic [MW-1:0] m_val,
    input  logic [1:0]    n_code,
    input  logic [2:0]    test_code,
    input  logic          shift_q,
    output logic          ref_div_o,
    output logic          fb_o,
    output logic          fout_o,
    output logic          test_o
);
    localparam int FBW  = MW + 1;
    localparam int REFW = $clog2(REF_DIV + 1);
    localparam int QW   = $clog2(QDIV + 1);
    localparam logic [MW-1:0] M_MIN = MW'(2);

    logic [MW-1:0]  m_eff;
    logic [FBW-1:0] m_ratio;
    logic           fout_edge;
    logic           ser_div;
    logic           quart;
    logic           unused_ref_edge, unused_fb_edge, unused_ser_edge, unused_q_edge;

    assign m_eff   = (m_val < M_MIN) ? M_MIN : m_val;
    assign m_ratio = {m_eff, 1'b0};

    sd_edge_div #(.W(REFW)) u_ref (
        .clk(clk), .rst(rst), .stb(ref_edge), .ratio(REFW'(REF_DIV)),
        .clk_o(ref_div_o), .edge_o(unused_ref_edge));

    sd_edge_div #(.W(FBW)) u_fb (
        .clk(clk), .rst(rst), .stb(vco_edge), .ratio(m_ratio),
        .clk_o(fb_o), .edge_o(unused_fb_edge));

    sd_edge_div #(.W(N_RATIO_W)) u_out (
        .clk(clk), .rst(rst), .stb(vco_edge), .ratio(n_ratio(n_code)),
        .clk_o(fout_o), .edge_o(fout_edge));

    sd_edge_div #(.W(FBW)) u_ser (
        .clk(clk), .rst(rst), .stb(ser_edge), .ratio(m_ratio),
        .clk_o(ser_div), .edge_o(unused_ser_edge));

    sd_edge_div #(.W(QW)) u_quart (
        .clk(clk), .rst(rst), .stb(fout_edge), .ratio(QW'(QDIV)),
        .clk_o(quart), .edge_o(unused_q_edge));

    sd_test_sel u_sel (
        .code(test_code), .shift_q(shift_q), .ref_div(ref_div_o), .fb(fb_o),
        .fout(fout_o), .ser_div(ser_div), .quart(quart), .test_o(test_o));

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!ref_div_o && !fb_o && !fout_o));

    assert_quarter_follows_fout_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(fout_o)) |-> $stable(quart));

endmodule

// File: tb/synth_div_chain_tb.sv
module synth_div_chain_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_edge = 1'b0, vco_edge = 1'b0, ser_edge = 1'b0;
    logic [8:0] m_val = 9'd2;
    logic [1:0] n_code = 2'b00;
    logic [2:0] test_code = 3'b000;
    logic       shift_q = 1'b0;
    logic       ref_div_o, fb_o, fout_o, test_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    synth_div_chain u_dut (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .vco_edge(vco_edge),
        .ser_edge(ser_edge), .m_val(m_val), .n_code(n_code),
        .test_code(test_code), .shift_q(shift_q), .ref_div_o(ref_div_o),
        .fb_o(fb_o), .fout_o(fout_o), .test_o(test_o));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return ref_div_o;
            1: return fb_o;
            2: return fout_o;
            default: return test_o;
        endcase
    endfunction

    task automatic measure(input int sel, output int cyc);
        logic prev;
        bit   seen;
        prev = pick(sel);
        cyc  = 0;
        seen = 0;
        while (!seen && cyc < 4000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (pick(sel) !== prev) seen = 1;
        end
    endtask

    task automatic fresh(input int m, input int n, input int t);
        @(negedge clk);
        ref_edge = 0; vco_edge = 0; ser_edge = 0;
        m_val = 9'(m); n_code = 2'(n); test_code = 3'(t);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c;
        int nexp[4];
        int mlist[6];
        logic h_ref, h_fb, h_fout, h_t;
        nexp = '{2, 4, 8, 1};
        mlist = '{2, 3, 100, 255, 350, 511};

        // R1: reset with all strobes active
        test_code = 3'b010;
        ref_edge = 1; vco_edge = 1; ser_edge = 1;
        repeat (4) @(negedge clk);
        chk("R1 ref_div_o", ref_div_o, 0);
        chk("R1 fb_o", fb_o, 0);
        chk("R1 fout_o", fout_o, 0);
        chk("R1 test_o", test_o, 0);

        // R2: reference divide by 16
        fresh(2, 0, 0); ref_edge = 1;
        measure(0, c); chk("R2 first", c, 16);
        measure(0, c); chk("R2 second", c, 16);

        // R3: every N code
        for (int n = 0; n < 4; n++) begin
            fresh(2, n, 0); vco_edge = 1;
            measure(2, c); chk($sformatf("R3 code%0d high", n), c, nexp[n]);
            measure(2, c); chk($sformatf("R3 code%0d low", n), c, nexp[n]);
        end

        // R4: feedback divide sweep
        foreach (mlist[i]) begin
            fresh(mlist[i], 0, 0); vco_edge = 1;
            measure(1, c); chk($sformatf("R4 M=%0d", mlist[i]), c, 2 * mlist[i]);
            measure(1, c); chk($sformatf("R4 M=%0d again", mlist[i]), c, 2 * mlist[i]);
        end

        // R5: clamp of small M
        for (int m = 0; m < 2; m++) begin
            fresh(m, 0, 0); vco_edge = 1;
            measure(1, c); chk($sformatf("R5 M=%0d", m), c, 4);
        end

        // R6: ratio change coinciding with a strobe
        fresh(2, 0, 0); vco_edge = 1;
        measure(2, c); chk("R6 before N change", c, 2);
        n_code = 2'b10;
        measure(2, c); chk("R6 after N change", c, 9);
        measure(2, c); chk("R6 settled N", c, 8);
        fresh(3, 0, 0); vco_edge = 1;
        measure(1, c); chk("R6 before M change", c, 6);
        m_val = 9'd5;
        measure(1, c); chk("R6 after M change", c, 11);
        measure(1, c); chk("R6 settled M", c, 10);

        // R7: shift bit, forced levels, output clock
        fresh(2, 0, 0);
        shift_q = 1; @(negedge clk); chk("R7 shift 1", test_o, 1);
        shift_q = 0; @(negedge clk); chk("R7 shift 0", test_o, 0);
        test_code = 3'b001; @(negedge clk); chk("R7 high", test_o, 1);
        test_code = 3'b101; shift_q = 1; vco_edge = 1;
        repeat (5) @(negedge clk); chk("R7 low", test_o, 0);
        fresh(2, 1, 4); vco_edge = 1;
        measure(3, c); chk("R7 fout on test", c, 4);

        // R8: reference and feedback on test pin
        fresh(2, 0, 2); ref_edge = 1;
        measure(3, c); chk("R8 ref on test", c, 16);
        fresh(3, 0, 3); vco_edge = 1;
        measure(3, c); chk("R8 fb on test", c, 6);

        // R9: serial clock path
        fresh(5, 0, 6); ser_edge = 1;
        measure(3, c); chk("R9 M=5", c, 10);
        fresh(0, 0, 6); ser_edge = 1;
        measure(3, c); chk("R9 clamp", c, 4);

        // R10: output clock divided by four
        fresh(2, 0, 7); vco_edge = 1;
        measure(3, c); chk("R10 N=2", c, 8);
        measure(3, c); chk("R10 N=2 again", c, 8);
        fresh(2, 3, 7); vco_edge = 1;
        measure(3, c); chk("R10 N=1", c, 4);

        // R11: outputs hold without strobes
        fresh(2, 0, 7); vco_edge = 1; ref_edge = 1;
        repeat (7) @(negedge clk);
        vco_edge = 0; ref_edge = 0;
        @(negedge clk);
        h_ref = ref_div_o; h_fb = fb_o; h_fout = fout_o; h_t = test_o;
        repeat (30) @(negedge clk);
        chk("R11 ref hold", ref_div_o, h_ref);
        chk("R11 fb hold", fb_o, h_fb);
        chk("R11 fout hold", fout_o, h_fout);
        chk("R11 quarter hold", test_o, h_t);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule